// File: doc/BRIEF.md
# I2C Slave Receive Controller

This block lets a chip act as an addressed target on a two-wire I2C bus when a bus master writes to it. It samples the clock and data lines through synchronisers and recognises START and STOP conditions. After each START it shifts in the first byte, which holds a 7-bit address followed by a direction bit. It accepts the byte when the address equals a programmable own address, or equals the all-zero general-call address while general-call answering is enabled. The block only responds while its enable input is high.

On an accepted write the block pulls SDA low through the ninth clock (ACK), raises an address-match flag and an interrupt, and then holds SCL low until software reads the status. After that each data byte is shifted in MSB first, placed in a receive register and flagged. The block answers each byte with ACK, or with NACK when software has set the refuse input. After every acknowledged byte SCL stays low until software has read the pending data. Both bus lines are open-drain: the outputs only say when to pull a line low.

The register side is a set of level inputs and read strobes. A one-cycle pulse on `statusRead` is a read of the status and clears the address-match flag. A pulse on `dataRead` is a read of the data register and clears the data-ready flag.

Top module: `i2c_slave_rx`

## Requirements
- R1: After reset, `sdaDriveLow`, `sclDriveLow`, `addrMatch`, `rxReady`, `rwFlag` and `irq` are all 0.
- R2: After a START (SDA falling while SCL is high), an address byte whose upper 7 bits equal `ownAddr` and whose bit 0 (direction) is 0 is acknowledged: SDA is held low during the ninth clock, and `addrMatch` becomes 1.
- R3: An address byte whose upper 7 bits match neither `ownAddr` nor an enabled general call gets no ACK and sets no flag. The data bytes that follow in that transaction are ignored: no ACK, and `rxReady` stays 0.
- R4: The address 7'b0000000 with direction 0 is acknowledged and sets `addrMatch` only while `genCallEn` is 1.
- R5: While `enable` is 0, even an own-address write gets no ACK and leaves `addrMatch` at 0.
- R6: An own-address byte with direction 1 (read) is not acknowledged and leaves `addrMatch` at 0, but sets `rwFlag` to 1. A later own-address write clears `rwFlag` to 0.
- R7: After the address ACK clock, `sclDriveLow` stays 1 until a `statusRead` pulse. That pulse clears `addrMatch`, and SCL is released within 3 cycles.
- R8: Each data byte is received MSB first. When the eighth bit completes, the byte appears on `rxData` and `rxReady` becomes 1. The byte is acknowledged while `nakBit` is 0.
- R9: While `nakBit` is 1, a received data byte is answered with NACK (SDA left high in the ninth clock). After that NACK, SCL is not held, and further bytes are ignored until the next START.
- R10: After an acknowledged data byte's ninth clock, `sclDriveLow` stays 1 while `rxReady` is 1. A `dataRead` pulse clears `rxReady` and SCL is released within 3 cycles.
- R11: A STOP (SDA rising while SCL is high), including one in the middle of a byte, returns the block to idle with both lines released. Bytes clocked after it without a START are ignored. A repeated START restarts the address phase.
- R12: `irq` is 1 exactly while `addrMatch` or `rxReady` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Sampled level of the SCL bus line |
| sdaIn | input | 1 | Sampled level of the SDA bus line |
| sclDriveLow | output | 1 | 1 = pull SCL low (clock stretch) |
| sdaDriveLow | output | 1 | 1 = pull SDA low (ACK) |
| enable | input | 1 | Slave response enable |
| genCallEn | input | 1 | Also answer the general-call address |
| nakBit | input | 1 | 1 = answer received data bytes with NACK |
| ownAddr | input | 7 | Programmable own 7-bit address |
| statusRead | input | 1 | One-cycle pulse: status is read, clears addrMatch |
| dataRead | input | 1 | One-cycle pulse: data is read, clears rxReady |
| addrMatch | output | 1 | Own or general-call write address accepted |
| rwFlag | output | 1 | Direction bit of the last own-address byte |
| rxReady | output | 1 | A new byte is waiting in rxData |
| rxData | output | 8 | Last received data byte |
| irq | output | 1 | Interrupt request |

## Verification
Address bytes are driven as own-address writes, own-address reads, a neighbouring address, and the general-call address with its enable both off and on. The own address is also sent with the slave disabled. Together these tell the compare, the direction check and the enable gate apart. Data bytes with different bit patterns are sent under ACK and NACK control, and the bench checks that SCL is held until the matching read strobe. STOP in the middle of a byte, bytes clocked without a START, and a repeated START show whether the control returns to idle and restarts cleanly.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = DATA_W - 1;
  localparam int CNT_W  = $clog2(DATA_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_DATA,
    ST_DATA_ACK
  } rx_state_t;

  // control -> datapath strobes
  typedef struct packed {
    logic receive;
    logic clearCount;
    logic loadRx;
  } ctrl_strobe_t;

  // datapath -> control observations
  typedef struct packed {
    logic sclFall;
    logic startDet;
    logic stopDet;
    logic byteDone;
    logic addrHit;
    logic dirBit;
  } dp_status_t;
endpackage

// File: rtl/i2c_rx_datapath.sv
module i2c_rx_datapath
  import i2c_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              genCallEn,
  input  ctrl_strobe_t      strb,
  output dp_status_t        stat,
  output logic [DATA_W-1:0] rxData
);
  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic sclRise;
  logic [DATA_W-1:0] shiftReg;
  logic [CNT_W-1:0]  bitCnt;

  // bus lines idle high, so synchronisers reset to 1
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];

  assign sclRise       = sclS & ~sclPrev;
  assign stat.sclFall  = ~sclS & sclPrev;
  assign stat.startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stat.stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

  // bit shifter, MSB first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (strb.clearCount) begin
      bitCnt <= '0;
    end else if (strb.receive && sclRise && (bitCnt != CNT_W'(DATA_W))) begin
      shiftReg <= {shiftReg[DATA_W-2:0], sdaS};
      bitCnt   <= bitCnt + CNT_W'(1);
    end
  end

  assign stat.byteDone = (bitCnt == CNT_W'(DATA_W));
  assign stat.dirBit   = shiftReg[0];
  assign stat.addrHit  = (shiftReg[DATA_W-1:1] == ownAddr) ||
                         (genCallEn && (shiftReg[DATA_W-1:1] == '0));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rxData <= '0;
    else if (strb.loadRx) rxData <= shiftReg;
  end
endmodule

// File: rtl/i2c_rx_control.sv
module i2c_rx_control
  import i2c_rx_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  dp_status_t   stat,
  input  logic         enable,
  input  logic         nakBit,
  input  logic         statusRead,
  input  logic         dataRead,
  output ctrl_strobe_t strb,
  output logic         addrMatch,
  output logic         rwFlag,
  output logic         rxReady,
  output logic         sdaDriveLow,
  output logic         sclDriveLow,
  output logic         irq
);
  rx_state_t state;
  logic ackDrive, stretchOn, nackPend;
  logic byteEnd, busEvent, addrAccept, pending;

  assign busEvent = stat.startDet | stat.stopDet;
  assign byteEnd  = stat.sclFall & stat.byteDone & ~busEvent;

  always_comb begin
    strb            = '0;
    strb.receive    = (state == ST_ADDR) || (state == ST_DATA);
    strb.clearCount = stat.startDet || (byteEnd && strb.receive);
    strb.loadRx     = (state == ST_DATA) && byteEnd;
  end

  assign addrAccept = (state == ST_ADDR) && byteEnd && enable &&
                      stat.addrHit && !stat.dirBit;
  // a flag still unserviced after this cycle's reads
  assign pending = (addrMatch & ~statusRead) | (rxReady & ~dataRead);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      ackDrive  <= 1'b0;
      stretchOn <= 1'b0;
      nackPend  <= 1'b0;
      rwFlag    <= 1'b0;
    end else if (stat.startDet) begin
      state     <= ST_ADDR;
      ackDrive  <= 1'b0;
      stretchOn <= 1'b0;
    end else if (stat.stopDet) begin
      state     <= ST_IDLE;
      ackDrive  <= 1'b0;
      stretchOn <= 1'b0;
    end else begin
      if (stretchOn && !pending) stretchOn <= 1'b0;
      case (state)
        ST_ADDR: begin
          if (byteEnd) begin
            if (enable && stat.addrHit) rwFlag <= stat.dirBit;
            if (addrAccept) begin
              ackDrive <= 1'b1;
              state    <= ST_ADDR_ACK;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (stat.sclFall) begin
            ackDrive  <= 1'b0;
            stretchOn <= pending;
            state     <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (byteEnd) begin
            ackDrive <= ~nakBit;
            nackPend <= nakBit;
            state    <= ST_DATA_ACK;
          end
        end
        ST_DATA_ACK: begin
          if (stat.sclFall) begin
            ackDrive <= 1'b0;
            if (nackPend) begin
              state <= ST_IDLE;
            end else begin
              stretchOn <= pending;
              state     <= ST_DATA;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // software-visible flags: setting wins over a read in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrMatch <= 1'b0;
      rxReady   <= 1'b0;
    end else begin
      if (addrAccept)      addrMatch <= 1'b1;
      else if (statusRead) addrMatch <= 1'b0;
      if (strb.loadRx)     rxReady <= 1'b1;
      else if (dataRead)   rxReady <= 1'b0;
    end
  end

  assign sdaDriveLow = ackDrive;
  assign sclDriveLow = stretchOn;
  assign irq         = addrMatch | rxReady;
endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx
  import i2c_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sclDriveLow,
  output logic       sdaDriveLow,
  input  logic       enable,
  input  logic       genCallEn,
  input  logic       nakBit,
  input  logic [6:0] ownAddr,
  input  logic       statusRead,
  input  logic       dataRead,
  output logic       addrMatch,
  output logic       rwFlag,
  output logic       rxReady,
  output logic [7:0] rxData,
  output logic       irq
);
  ctrl_strobe_t ctrlStrb;
  dp_status_t   dpStat;

  i2c_rx_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .ownAddr   (ownAddr),
    .genCallEn (genCallEn),
    .strb      (ctrlStrb),
    .stat      (dpStat),
    .rxData    (rxData)
  );

  i2c_rx_control u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .stat        (dpStat),
    .enable      (enable),
    .nakBit      (nakBit),
    .statusRead  (statusRead),
    .dataRead    (dataRead),
    .strb        (ctrlStrb),
    .addrMatch   (addrMatch),
    .rwFlag      (rwFlag),
    .rxReady     (rxReady),
    .sdaDriveLow (sdaDriveLow),
    .sclDriveLow (sclDriveLow),
    .irq         (irq)
  );
endmodule

// File: rtl/i2c_slave_rx_chk.sv
module i2c_slave_rx_chk (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic sdaDriveLow,
  input logic sclDriveLow,
  input logic enable,
  input logic addrMatch,
  input logic rxReady,
  input logic statusRead,
  input logic dataRead,
  input logic loadRx,
  input logic sclFall
);
  // R2
  ack_in_low_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> !sclIn);

  // R5
  match_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(addrMatch) |-> $past(enable));

  // R7
  status_read_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !sclFall) |=> !addrMatch);

  // R10
  data_read_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataRead && !loadRx) |=> !rxReady);

  // R10
  stretch_sda_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    sclDriveLow |-> !sdaDriveLow);
endmodule

bind i2c_slave_rx i2c_slave_rx_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .sclIn       (sclIn),
  .sdaDriveLow (sdaDriveLow),
  .sclDriveLow (sclDriveLow),
  .enable      (enable),
  .addrMatch   (addrMatch),
  .rxReady     (rxReady),
  .statusRead  (statusRead),
  .dataRead    (dataRead),
  .loadRx      (ctrlStrb.loadRx),
  .sclFall     (dpStat.sclFall)
);

// File: tb/tb_i2c_slave_rx.sv
module tb_i2c_slave_rx;
  localparam int HALF = 20;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN;
  logic mScl = 1'b1, mSda = 1'b1;
  logic sclBus, sdaBus;
  logic sclDriveLow, sdaDriveLow;
  logic enable, genCallEn, nakBit, statusRead, dataRead;
  logic [6:0] ownAddr;
  logic addrMatch, rwFlag, rxReady, irq;
  logic [7:0] rxData;

  int checks = 0;
  int fails = 0;

  // open-drain wired-AND bus
  assign sclBus = mScl & ~sclDriveLow;
  assign sdaBus = mSda & ~sdaDriveLow;

  i2c_slave_rx dut (
    .clk(clk), .rstN(rstN), .sclIn(sclBus), .sdaIn(sdaBus),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
    .enable(enable), .genCallEn(genCallEn), .nakBit(nakBit),
    .ownAddr(ownAddr), .statusRead(statusRead), .dataRead(dataRead),
    .addrMatch(addrMatch), .rwFlag(rwFlag), .rxReady(rxReady),
    .rxData(rxData), .irq(irq)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic busStart();
    mSda = 1'b1; cyc(HALF / 2);
    mScl = 1'b1;
    while (!sclBus) cyc(1);
    cyc(HALF);
    mSda = 1'b0; cyc(HALF);
    mScl = 1'b0; cyc(HALF / 2);
  endtask

  task automatic busStop();
    mSda = 1'b0; cyc(HALF);
    mScl = 1'b1;
    while (!sclBus) cyc(1);
    cyc(HALF);
    mSda = 1'b1; cyc(HALF);
  endtask

  task automatic clockBit(input logic b, output logic s);
    mSda = b; cyc(HALF);
    mScl = 1'b1;
    while (!sclBus) cyc(1);
    cyc(HALF / 2);
    s = sdaBus;
    cyc(HALF / 2);
    mScl = 1'b0; cyc(2);
  endtask

  // returns the ninth-bit level: 0 = ACK, 1 = NACK
  task automatic writeByte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(b[i], s);
    clockBit(1'b1, ack);
  endtask

  task automatic readStatus();
    statusRead = 1'b1; cyc(1); statusRead = 1'b0;
  endtask

  task automatic readData();
    dataRead = 1'b1; cyc(1); dataRead = 1'b0;
  endtask

  task automatic testReset();
    check("R1 sdaDriveLow", sdaDriveLow, 0);
    check("R1 sclDriveLow", sclDriveLow, 0);
    check("R1 addrMatch", addrMatch, 0);
    check("R1 rxReady", rxReady, 0);
    check("R1 rwFlag", rwFlag, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic testBasicWrite();
    logic ack;
    busStart();
    writeByte({OWN, 1'b0}, ack);
    check("R2 address ACK", ack, 0);
    cyc(8);
    check("R2 addrMatch", addrMatch, 1);
    check("R12 irq on addrMatch", irq, 1);
    check("R6 rwFlag write", rwFlag, 0);
    check("R7 SCL held", sclDriveLow, 1);
    cyc(40);
    check("R7 SCL still held", sclDriveLow, 1);
    readStatus(); cyc(3);
    check("R7 addrMatch cleared", addrMatch, 0);
    check("R7 SCL released", sclDriveLow, 0);
    check("R12 irq low", irq, 0);
    writeByte(8'hA5, ack);
    check("R8 data ACK", ack, 0);
    cyc(8);
    check("R8 rxData A5", rxData, 8'hA5);
    check("R8 rxReady", rxReady, 1);
    check("R12 irq on rxReady", irq, 1);
    check("R10 SCL held on data", sclDriveLow, 1);
    cyc(40);
    check("R10 SCL still held", sclDriveLow, 1);
    readData(); cyc(3);
    check("R10 rxReady cleared", rxReady, 0);
    check("R10 SCL released", sclDriveLow, 0);
    writeByte(8'h3C, ack);
    check("R8 second ACK", ack, 0);
    cyc(8);
    check("R8 rxData 3C", rxData, 8'h3C);
    readData(); cyc(3);
    busStop(); cyc(5);
    check("R11 SDA free after STOP", sdaDriveLow, 0);
    check("R11 SCL free after STOP", sclDriveLow, 0);
  endtask

  task automatic testWrongAddr();
    logic ack;
    busStart();
    writeByte({7'h5B, 1'b0}, ack);
    check("R3 no ACK wrong address", ack, 1);
    cyc(8);
    check("R3 addrMatch stays 0", addrMatch, 0);
    check("R3 irq stays 0", irq, 0);
    writeByte(8'h77, ack);
    check("R3 data ignored no ACK", ack, 1);
    cyc(8);
    check("R3 rxReady stays 0", rxReady, 0);
    busStop(); cyc(5);
  endtask

  task automatic testGeneralCall();
    logic ack;
    genCallEn = 1'b0;
    busStart();
    writeByte(8'h00, ack);
    check("R4 general call off no ACK", ack, 1);
    cyc(8);
    check("R4 general call off no match", addrMatch, 0);
    busStop(); cyc(5);
    genCallEn = 1'b1;
    busStart();
    writeByte(8'h00, ack);
    check("R4 general call on ACK", ack, 0);
    cyc(8);
    check("R4 general call on match", addrMatch, 1);
    readStatus(); cyc(3);
    busStop(); cyc(5);
    genCallEn = 1'b0;
  endtask

  task automatic testDisabled();
    logic ack;
    enable = 1'b0;
    busStart();
    writeByte({OWN, 1'b0}, ack);
    check("R5 disabled no ACK", ack, 1);
    cyc(8);
    check("R5 disabled no match", addrMatch, 0);
    busStop(); cyc(5);
    enable = 1'b1;
  endtask

  task automatic testReadDir();
    logic ack;
    busStart();
    writeByte({OWN, 1'b1}, ack);
    check("R6 read direction no ACK", ack, 1);
    cyc(8);
    check("R6 read no addrMatch", addrMatch, 0);
    check("R6 rwFlag set", rwFlag, 1);
    check("R6 no stretch on read", sclDriveLow, 0);
    busStart();
    writeByte({OWN, 1'b0}, ack);
    check("R11 repeated START ACK", ack, 0);
    cyc(8);
    check("R6 rwFlag cleared", rwFlag, 0);
    readStatus(); cyc(3);
    busStop(); cyc(5);
  endtask

  task automatic testNak();
    logic ack;
    busStart();
    writeByte({OWN, 1'b0}, ack);
    cyc(4); readStatus(); cyc(3);
    nakBit = 1'b1;
    writeByte(8'h81, ack);
    check("R9 NACK returned", ack, 1);
    cyc(8);
    check("R9 rxData 81", rxData, 8'h81);
    check("R9 no stretch after NACK", sclDriveLow, 0);
    readData(); cyc(3);
    writeByte(8'h42, ack);
    check("R9 later byte no ACK", ack, 1);
    cyc(8);
    check("R9 later byte ignored", rxData, 8'h81);
    check("R9 later byte no ready", rxReady, 0);
    busStop(); cyc(5);
    nakBit = 1'b0;
  endtask

  task automatic testStopMidByte();
    logic ack, s;
    busStart();
    writeByte({OWN, 1'b0}, ack);
    cyc(4); readStatus(); cyc(3);
    clockBit(1'b1, s); clockBit(1'b0, s); clockBit(1'b1, s);
    busStop(); cyc(5);
    check("R11 lines free after early STOP", {sdaDriveLow, sclDriveLow}, 0);
    writeByte(8'hF0, ack);
    check("R11 byte after STOP ignored", ack, 1);
    cyc(8);
    check("R11 no ready after STOP", rxReady, 0);
    busStart();
    writeByte({OWN, 1'b0}, ack);
    check("R11 new START works", ack, 0);
    cyc(4); readStatus(); cyc(3);
    busStop(); cyc(5);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0;
    enable = 1'b1; genCallEn = 1'b0; nakBit = 1'b0;
    statusRead = 1'b0; dataRead = 1'b0; ownAddr = OWN;
    cyc(5);
    rstN = 1'b1;
    cyc(5);
    testReset();
    testBasicWrite();
    testWrongAddr();
    testGeneralCall();
    testDisabled();
    testReadDir();
    testNak();
    testStopMidByte();
    summary();
    $finish;
  end
endmodule